// File: doc/BRIEF.md
# DMA Channel Trigger and Burst Controller

This block holds the trigger logic for one channel of a simple DMA engine. A configuration byte sets how the channel starts work. The trigger input can start it on an edge or on a level, with the active sense chosen by a polarity bit. Each accepted trigger starts either one transfer or a burst of 2^N transfers. Peripheral request pacing can also be turned on, so that an element moves only while the peripheral asks for one.

The block issues a one-cycle transfer request for each element. After each request it waits for the datapath's completion strobe. It counts elements down until the burst is finished. A busy output covers the whole burst. A synchronous channel disable stops any burst in progress and discards a pending trigger. Address generation, bus mastering and trigger-source routing belong to other blocks.

Top module: `dma_trig_ctrl`

## Requirements
- R1: During and right after reset, `xfer_req_o` and `busy_o` are low.
- R2: With `cfg_i[3]`=0 the trigger is edge sensitive. With `cfg_i[2]`=1 a rising edge of `trig_i` starts a burst, and with `cfg_i[2]`=0 a falling edge does. An edge in the opposite direction starts nothing.
- R3: With `cfg_i[3]`=1 the trigger is level sensitive. It is active while `trig_i` equals `cfg_i[2]`, and new bursts keep starting back to back for as long as it stays active.
- R4: Once a burst has started it runs to its full length, even if a level trigger goes inactive partway through.
- R5: With `cfg_i[1]`=0 the trigger input is ignored: no burst starts and `xfer_req_o` stays low.
- R6: With `cfg_i[4]`=0 a trigger gives exactly one transfer, whatever `cfg_i[7:5]` holds. With `cfg_i[4]`=1 it gives 2^N transfers, where N=`cfg_i[7:5]`, up to 128 for N=7.
- R7: `xfer_req_o` is a single-cycle pulse, one per element. After a pulse, the next one waits until `xfer_done_i` has been seen.
- R8: With `cfg_i[0]`=1, `xfer_req_o` is issued only in cycles where `preq_i` is high. The request waits while `preq_i` is low.
- R9: When `chan_dis_i` is high at a clock edge, any burst is aborted and a pending edge is discarded. `busy_o` and `xfer_req_o` are low from the next cycle on.
- R10: `busy_o` rises when a trigger is accepted. It stays high until the completion of the last transfer of the burst, and falls in the cycle after that completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_dis_i | input | 1 | Synchronous channel disable / abort |
| cfg_i | input | 8 | Channel configuration byte |
| trig_i | input | 1 | Hardware trigger input |
| preq_i | input | 1 | Peripheral request line |
| xfer_done_i | input | 1 | Element completion strobe from the datapath |
| xfer_req_o | output | 1 | One-cycle request per element |
| busy_o | output | 1 | High while a burst is active |

## Verification
The assertions check several properties on every cycle. `xfer_req_o` never lasts more than one cycle and never appears outside `busy_o`. Pacing keeps requests off while `preq_i` is low. Disable clears the block on the next cycle. A channel with its trigger disabled never turns busy. `busy_o` only falls after a completion or a disable. Only the bench scenarios can show that the number of requests matches the burst length and the polarity and edge or level selection. They also show that a burst runs on after a level drops, and that an aborted burst leaves no pending trigger behind.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
    localparam int POW_W   = 3;
    localparam int MAX_POW = (1 << POW_W) - 1;
    localparam int CNT_W   = MAX_POW + 1;

    typedef struct packed {
        logic [POW_W-1:0] pow;
        logic             burst;
        logic             level;
        logic             pol_hi;
        logic             hw_en;
        logic             pace;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/dma_trig_qual.sv
module dma_trig_qual
    import dma_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dis_i,
    input  chan_cfg_t cfg_i,
    input  logic      trig_i,
    input  logic      accept_i,
    output logic      fire_o
);
    typedef struct packed {
        logic trig;
        logic pending;
    } qual_t;

    qual_t q, d;
    logic  act_now;
    logic  act_prev;
    logic  edge_hit;

    always_comb begin
        act_now  = cfg_i.pol_hi ? trig_i : ~trig_i;
        act_prev = cfg_i.pol_hi ? q.trig : ~q.trig;
        edge_hit = cfg_i.hw_en & ~cfg_i.level & act_now & ~act_prev;

        d.trig    = trig_i;
        d.pending = (q.pending & ~accept_i) | edge_hit;
        if (dis_i || !cfg_i.hw_en || cfg_i.level) begin
            d.pending = 1'b0;
        end

        fire_o = cfg_i.hw_en & (cfg_i.level ? act_now : q.pending);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dis_i,
    input  chan_cfg_t cfg_i,
    input  logic      fire_i,
    input  logic      preq_i,
    input  logic      done_i,
    output logic      accept_o,
    output logic      req_o,
    output logic      busy_o
);
    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t             q, d;
    logic [CNT_W-1:0] burst_len;
    logic             may_issue;

    always_comb begin
        burst_len = cfg_i.burst ? (CNT_W'(1) << cfg_i.pow) : CNT_W'(1);
        may_issue = preq_i | ~cfg_i.pace;

        d        = q;
        accept_o = 1'b0;
        req_o    = 1'b0;

        unique case (q.st)
            SQ_IDLE: begin
                if (fire_i) begin
                    accept_o = 1'b1;
                    d.cnt    = burst_len;
                    d.st     = SQ_ISSUE;
                end
            end
            SQ_ISSUE: begin
                if (may_issue) begin
                    req_o = 1'b1;
                    d.st  = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (done_i) begin
                    d.cnt = q.cnt - CNT_W'(1);
                    d.st  = (q.cnt == CNT_W'(1)) ? SQ_IDLE : SQ_ISSUE;
                end
            end
            default: d.st = SQ_IDLE;
        endcase

        if (dis_i) begin
            accept_o = 1'b0;
            req_o    = 1'b0;
            d.st     = SQ_IDLE;
            d.cnt    = '0;
        end

        busy_o = (q.st != SQ_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= SQ_IDLE;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
    import dma_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_dis_i,
    input  logic [7:0] cfg_i,
    input  logic       trig_i,
    input  logic       preq_i,
    input  logic       xfer_done_i,
    output logic       xfer_req_o,
    output logic       busy_o
);
    chan_cfg_t cfg;
    logic      fire;
    logic      accept;

    assign cfg = chan_cfg_t'(cfg_i);

    dma_trig_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .dis_i    (chan_dis_i),
        .cfg_i    (cfg),
        .trig_i   (trig_i),
        .accept_i (accept),
        .fire_o   (fire)
    );

    dma_burst_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .dis_i    (chan_dis_i),
        .cfg_i    (cfg),
        .fire_i   (fire),
        .preq_i   (preq_i),
        .done_i   (xfer_done_i),
        .accept_o (accept),
        .req_o    (xfer_req_o),
        .busy_o   (busy_o)
    );
endmodule

// File: rtl/dma_trig_ctrl_chk.sv
module dma_trig_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chan_dis_i,
    input logic [7:0] cfg_i,
    input logic       preq_i,
    input logic       xfer_done_i,
    input logic       xfer_req_o,
    input logic       busy_o
);
    a_r7_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |=> !xfer_req_o);

    a_r10_req_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> busy_o);

    a_r8_pace_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[0] && !preq_i) |-> !xfer_req_o);

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        chan_dis_i |=> (!busy_o && !xfer_req_o));

    a_r5_no_start_untriggered: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i[1] && !busy_o) |=> !busy_o);

    a_r10_busy_falls_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(xfer_done_i) || $past(chan_dis_i)));
endmodule

bind dma_trig_ctrl dma_trig_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_dis_i  (chan_dis_i),
    .cfg_i       (cfg_i),
    .preq_i      (preq_i),
    .xfer_done_i (xfer_done_i),
    .xfer_req_o  (xfer_req_o),
    .busy_o      (busy_o)
);

// File: tb/dma_trig_ctrl_tb_top.sv
module dma_trig_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_dis = 1'b0;
    logic [7:0] cfg = 8'h00;
    logic       trig = 1'b0;
    logic       preq = 1'b0;
    logic       xfer_done;
    logic       xfer_req;
    logic       busy;

    logic       resp_en = 1'b1;
    logic       resp_pend = 1'b0;
    logic       resp_done = 1'b0;
    logic       man_done = 1'b0;
    int         pulse_cnt = 0;
    int         checks = 0;
    int         failures = 0;
    bit         finished = 1'b0;

    assign xfer_done = resp_done | man_done;

    always #4 clk = ~clk;

    dma_trig_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_dis_i  (chan_dis),
        .cfg_i       (cfg),
        .trig_i      (trig),
        .preq_i      (preq),
        .xfer_done_i (xfer_done),
        .xfer_req_o  (xfer_req),
        .busy_o      (busy)
    );

    // datapath model: completion two negedges after a request is seen
    always @(negedge clk) begin
        if (xfer_req) pulse_cnt <= pulse_cnt + 1;
        resp_done <= resp_en & resp_pend;
        resp_pend <= resp_en & xfer_req;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0] cfg;
        logic       init;
        logic       fin;
        logic       pulse;
        logic       preq;
        logic [8:0] exp_cnt;
        logic       exp_busy;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h06, 1'b0, 1'b1, 1'b0, 1'b0, 9'd1,   1'b0}, // R2 rising edge, single
        '{8'h76, 1'b0, 1'b1, 1'b0, 1'b0, 9'd8,   1'b0}, // R6 N=3 burst
        '{8'h52, 1'b1, 1'b0, 1'b0, 1'b0, 9'd4,   1'b0}, // R2 falling edge, N=2
        '{8'h06, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R2 wrong edge
        '{8'h14, 1'b0, 1'b1, 1'b0, 1'b0, 9'd0,   1'b0}, // R5 trigger disabled, edge
        '{8'h1C, 1'b0, 1'b1, 1'b0, 1'b0, 9'd0,   1'b0}, // R5 trigger disabled, level
        '{8'hF6, 1'b0, 1'b1, 1'b0, 1'b0, 9'd128, 1'b0}, // R6 N=7 burst
        '{8'h5E, 1'b0, 1'b1, 1'b1, 1'b0, 9'd4,   1'b0}, // R4 level high, short pulse
        '{8'h3A, 1'b1, 1'b0, 1'b1, 1'b0, 9'd2,   1'b0}, // R4 level low, short pulse
        '{8'hE6, 1'b0, 1'b1, 1'b0, 1'b0, 9'd1,   1'b0}, // R6 burst bit clear
        '{8'h07, 1'b0, 1'b1, 1'b0, 1'b0, 9'd0,   1'b1}, // R8 paced, no request
        '{8'h77, 1'b0, 1'b1, 1'b0, 1'b1, 9'd8,   1'b0}  // R8 paced, request high
    };

    task automatic setup(input logic [7:0] c, input logic init, input logic pr);
        @(negedge clk);
        chan_dis = 1'b1;
        cfg = c;
        trig = init;
        preq = pr;
        repeat (3) @(negedge clk);
        chan_dis = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 req in reset", int'(xfer_req), 0);
        check("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req after reset", int'(xfer_req), 0);
        check("R1 busy after reset", int'(busy), 0);

        for (int i = 0; i < NV; i++) begin
            int base;
            setup(VECS[i].cfg, VECS[i].init, VECS[i].preq);
            base = pulse_cnt;
            trig = VECS[i].fin;
            if (VECS[i].pulse) begin
                @(negedge clk);
                trig = VECS[i].init;
            end
            repeat (500) @(negedge clk);
            check($sformatf("R2/R4/R5/R6/R8 vec%0d count", i), pulse_cnt - base, int'(VECS[i].exp_cnt));
            check($sformatf("R10 vec%0d busy", i), int'(busy), int'(VECS[i].exp_busy));
        end

        // R8: paced request resumes when preq rises
        begin
            int base;
            setup(8'h07, 1'b0, 1'b0);
            base = pulse_cnt;
            trig = 1'b1;
            repeat (20) @(negedge clk);
            check("R8 held while preq low", pulse_cnt - base, 0);
            check("R8 busy while held", int'(busy), 1);
            preq = 1'b1;
            repeat (50) @(negedge clk);
            check("R8 issued after preq", pulse_cnt - base, 1);
            check("R8 busy cleared", int'(busy), 0);
            preq = 1'b0;
        end

        // R9: abort mid-burst, no leftover pending
        begin
            int base;
            setup(8'hF6, 1'b0, 1'b0);
            base = pulse_cnt;
            trig = 1'b1;
            while (pulse_cnt - base < 10) @(negedge clk);
            chan_dis = 1'b1;
            @(negedge clk);
            chan_dis = 1'b0;
            check("R9 busy after abort", int'(busy), 0);
            check("R9 req after abort", int'(xfer_req), 0);
            base = pulse_cnt;
            repeat (400) @(negedge clk);
            check("R9 no restart after abort", pulse_cnt - base, 0);
        end

        // R3: level held keeps starting single transfers
        begin
            int base;
            setup(8'h0E, 1'b0, 1'b0);
            base = pulse_cnt;
            trig = 1'b1;
            repeat (100) @(negedge clk);
            trig = 1'b0;
            check("R3 back-to-back bursts", int'((pulse_cnt - base) >= 25), 1);
            repeat (10) @(negedge clk);
        end

        // R7/R10: cycle timing and wait for completion
        begin
            setup(8'h06, 1'b0, 1'b0);
            resp_en = 1'b0;
            trig = 1'b1;
            @(negedge clk);
            check("R10 busy before accept", int'(busy), 0);
            @(negedge clk);
            check("R10 busy at accept", int'(busy), 1);
            check("R7 req issued", int'(xfer_req), 1);
            @(negedge clk);
            check("R7 req single cycle", int'(xfer_req), 0);
            repeat (5) @(negedge clk);
            check("R7 waits for done", int'(xfer_req), 0);
            check("R10 busy while waiting", int'(busy), 1);
            man_done = 1'b1;
            @(negedge clk);
            man_done = 1'b0;
            check("R10 busy after last done", int'(busy), 0);
            resp_en = 1'b1;
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule